// File: doc/BRIEF.md
# Manual encryption job controller

This block sequences a single software-driven encryption job on the write path to external flash. Software fills a 64-byte plaintext window and sets three job parameters: a line-size code, a destination bit and a physical flash address. It then drives the job forward with three one-shot command bits. Trigger starts the computation, release exposes the finished result to the memory path, and destroy discards it.

The cipher itself sits outside the block. The controller hands it the plaintext, line size and address together with a one-cycle start pulse. It captures the engine's output when the engine reports completion. The captured result stays hidden until software releases it. While hidden, the result output is held at zero. Once released, the result-visible output goes high and the result is presented. Destroy wipes the internal result buffer.

A side-channel control word selects the countermeasure settings passed to the engine. The settings come either from the word itself or from externally fused inputs.

Top module: `crypt_job_ctrl`

## Requirements
- R1: After reset, the state field reads 0 and the error flag reads 0. The line-size, destination and address registers read 0. The version word reads 0x20201010. The side-channel word reads 0x0F (level 7, both-keys bit set, source bit clear). resultVisible and engStart are low.
- R2: A trigger (write of bit 0 = 1 at 0x34C) in state 0 with valid parameters moves the state to 1. It pulses engStart for exactly one cycle. While that pulse is high, engPlain carries window word i on bits [32i+31:32i], and engLineSize/engAddr carry the parameters.
- R3: engDone in state 1 moves the state to 2 and captures engResult. In state 2, resultVisible stays low and resultData is zero.
- R4: A release (bit 0 = 1 at 0x350) in state 2 moves the state to 3. resultVisible then goes high and resultData equals the captured result.
- R5: A destroy (bit 0 = 1 at 0x354) in state 3 returns the state to 0 and clears the result buffer. resultVisible goes low and resultData reads zero.
- R6: Each command that arrives outside its one legal state leaves the state unchanged: trigger outside 0, release outside 2, destroy outside 3. engDone outside state 1 is ignored. The three command offsets always read 0.
- R7: Line-size code 0, 1 and 2 select 16, 32 and 64 bytes per job, and the address must be a multiple of that count. A trigger in state 0 is rejected in any of three cases: code 3, a misaligned address, or destination 1. A rejected trigger keeps the state at 0, gives no engStart, and sets the sticky error flag (bit 8 of the state word at 0x358, state in bits 1:0). The next accepted trigger clears the flag.
- R8: The window occupies 16 words at 0x300-0x33C and reads back what was written. In any nonzero state, writes to the window, to the parameter registers (0x340 line size, 0x344 destination, 0x348 address) and to the side-channel word are ignored.
- R9: The side-channel word at 0x388 has three fields: level in bits 2:0, both-keys in bit 3 and source in bit 4. With source 1, scLevel and the both-keys setting come from the word. With source 0, they come from fuseLevel and fuseBothKeys. scBothKeys is forced low whenever the effective level is 0.
- R10: The address register keeps only the low 26 bits of a write, and the version word at 0x35C ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write enable |
| busAddr | input | 12 | Byte offset for read and write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| engStart | output | 1 | One-cycle start pulse to the cipher engine |
| engPlain | output | 512 | Plaintext window contents |
| engLineSize | output | 2 | Line-size code of the job |
| engAddr | output | 26 | Physical flash address of the job |
| engDone | input | 1 | Engine completion pulse |
| engResult | input | 512 | Engine result, valid with engDone |
| fuseLevel | input | 3 | Fused countermeasure level |
| fuseBothKeys | input | 1 | Fused both-keys setting |
| scLevel | output | 3 | Effective countermeasure level |
| scBothKeys | output | 1 | Effective both-keys protection |
| resultVisible | output | 1 | Result released to the memory path |
| resultData | output | 512 | Released result, zero while hidden |

## Verification
The assertions assume the engine raises engDone for a single cycle, and only after a start pulse. They also assume busAddr is stable whenever busWe is high. The bench engine model returns the bitwise inverse of the plaintext a fixed number of cycles after each start pulse. A separate task injects stray done pulses only to probe the ignore rule. All bus traffic is driven on the falling clock edge with one access per cycle, so every write lands at exactly one rising edge.

// File: rtl/crypt_job_pkg.sv
package crypt_job_pkg;

  localparam int REG_AW  = 12;
  localparam int DATA_W  = 32;

  localparam logic [REG_AW-1:0] OFF_WIN   = 12'h300;
  localparam logic [REG_AW-1:0] OFF_LINE  = 12'h340;
  localparam logic [REG_AW-1:0] OFF_DEST  = 12'h344;
  localparam logic [REG_AW-1:0] OFF_ADDR  = 12'h348;
  localparam logic [REG_AW-1:0] OFF_TRIG  = 12'h34C;
  localparam logic [REG_AW-1:0] OFF_REL   = 12'h350;
  localparam logic [REG_AW-1:0] OFF_KILL  = 12'h354;
  localparam logic [REG_AW-1:0] OFF_STATE = 12'h358;
  localparam logic [REG_AW-1:0] OFF_VER   = 12'h35C;
  localparam logic [REG_AW-1:0] OFF_SCW   = 12'h388;

  typedef enum logic [1:0] {
    JOB_IDLE   = 2'd0,
    JOB_BUSY   = 2'd1,
    JOB_HIDDEN = 2'd2,
    JOB_SHOWN  = 2'd3
  } jobState_t;

  // strobes from the control FSM to the register datapath
  typedef struct packed {
    logic paramWrOk;
    logic captureResult;
    logic clearResult;
  } jobStrobe_t;

  // address must be a multiple of the byte count picked by the line-size code
  function automatic logic lineAligned(input logic [1:0] ls, input logic [5:0] lo);
    case (ls)
      2'd0:    return lo[3:0] == 4'd0;
      2'd1:    return lo[4:0] == 5'd0;
      2'd2:    return lo == 6'd0;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/crypt_job_fsm.sv
module crypt_job_fsm
  import crypt_job_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [REG_AW-1:0]   busAddr,
  input  logic                cmdBit,
  input  logic [1:0]          lineSize,
  input  logic                destSel,
  input  logic [5:0]          addrLow,
  input  logic                engDone,
  output jobState_t           state,
  output logic                errFlag,
  output logic                engStart,
  output jobStrobe_t          strb
);

  logic trigCmd, relCmd, killCmd, paramsOk, trigAccept;
  jobState_t stateNxt;

  assign trigCmd  = busWe && cmdBit && (busAddr == OFF_TRIG);
  assign relCmd   = busWe && cmdBit && (busAddr == OFF_REL);
  assign killCmd  = busWe && cmdBit && (busAddr == OFF_KILL);
  assign paramsOk = !destSel && lineAligned(lineSize, addrLow);
  assign trigAccept = (state == JOB_IDLE) && trigCmd && paramsOk;

  always_comb begin
    stateNxt = state;
    case (state)
      JOB_IDLE:   if (trigAccept) stateNxt = JOB_BUSY;
      JOB_BUSY:   if (engDone)    stateNxt = JOB_HIDDEN;
      JOB_HIDDEN: if (relCmd)     stateNxt = JOB_SHOWN;
      JOB_SHOWN:  if (killCmd)    stateNxt = JOB_IDLE;
      default:                    stateNxt = JOB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= JOB_IDLE;
      errFlag  <= 1'b0;
      engStart <= 1'b0;
    end else begin
      state    <= stateNxt;
      engStart <= trigAccept;
      if ((state == JOB_IDLE) && trigCmd) errFlag <= !paramsOk;
    end
  end

  always_comb begin
    strb.paramWrOk     = (state == JOB_IDLE);
    strb.captureResult = (state == JOB_BUSY) && engDone;
    strb.clearResult   = (state == JOB_SHOWN) && killCmd;
  end

  // R6: only the four lifecycle steps ever change the state
  a_r6_legal_step: assert property (@(posedge clk) disable iff (!rstN)
    (state != $past(state)) |->
      (($past(state) == JOB_IDLE   && state == JOB_BUSY)   ||
       ($past(state) == JOB_BUSY   && state == JOB_HIDDEN) ||
       ($past(state) == JOB_HIDDEN && state == JOB_SHOWN)  ||
       ($past(state) == JOB_SHOWN  && state == JOB_IDLE)));

  // R2: start pulse lasts one cycle and coincides with the busy state
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (state == JOB_BUSY));

  // R7: a pending error can only exist while the job is idle
  a_r7_err_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (state == JOB_IDLE));

endmodule

// File: rtl/crypt_job_regs.sv
module crypt_job_regs
  import crypt_job_pkg::*;
#(
  parameter int              ADDR_W    = 26,
  parameter int              WIN_BYTES = 64,
  parameter int              VER_W     = 30,
  parameter logic [VER_W-1:0] VERSION  = 30'h20201010
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWe,
  input  logic [REG_AW-1:0]       busAddr,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  input  jobStrobe_t              strb,
  input  jobState_t               state,
  input  logic                    errFlag,
  input  logic                    showResult,
  input  logic [WIN_BYTES*8-1:0]  engResult,
  input  logic [2:0]              fuseLevel,
  input  logic                    fuseBothKeys,
  output logic [WIN_BYTES*8-1:0]  engPlain,
  output logic [1:0]              lineSize,
  output logic                    destSel,
  output logic [ADDR_W-1:0]       jobAddr,
  output logic [2:0]              scLevel,
  output logic                    scBothKeys,
  output logic [WIN_BYTES*8-1:0]  resultData
);

  localparam int WIN_WORDS = WIN_BYTES / 4;
  localparam int WIN_AW    = $clog2(WIN_BYTES);
  localparam int IDX_W     = $clog2(WIN_WORDS);
  localparam int RES_W     = WIN_BYTES * 8;
  localparam logic [4:0] SCW_RESET = 5'h0F;

  logic [DATA_W-1:0] winMem [WIN_WORDS];
  logic [RES_W-1:0]  resultBuf;
  logic [4:0]        scwReg;
  logic [REG_AW-1:0] winOff;
  logic              winHit;
  logic [IDX_W-1:0]  winIdx;
  logic              wrOk;

  assign winOff = busAddr - OFF_WIN;
  assign winHit = (winOff[REG_AW-1:WIN_AW] == '0) && (winOff[1:0] == 2'b00);
  assign winIdx = winOff[IDX_W+1:2];
  assign wrOk   = busWe && strb.paramWrOk;

  // plaintext window, one register per word
  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) winMem[w] <= '0;
      else if (wrOk && winHit && (winIdx == IDX_W'(w))) winMem[w] <= busWdata;
    end
    assign engPlain[w*DATA_W +: DATA_W] = winMem[w];
  end

  // job parameters and side-channel word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSize <= 2'd0;
      destSel  <= 1'b0;
      jobAddr  <= '0;
      scwReg   <= SCW_RESET;
    end else if (wrOk) begin
      case (busAddr)
        OFF_LINE: lineSize <= busWdata[1:0];
        OFF_DEST: destSel  <= busWdata[0];
        OFF_ADDR: jobAddr  <= busWdata[ADDR_W-1:0];
        OFF_SCW:  scwReg   <= busWdata[4:0];
        default: ;
      endcase
    end
  end

  // result buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   resultBuf <= '0;
    else if (strb.clearResult)   resultBuf <= '0;
    else if (strb.captureResult) resultBuf <= engResult;
  end

  assign resultData = showResult ? resultBuf : '0;

  // effective countermeasure settings
  logic [2:0] effLevel;
  logic       effBoth;
  assign effLevel   = scwReg[4] ? scwReg[2:0] : fuseLevel;
  assign effBoth    = scwReg[4] ? scwReg[3]   : fuseBothKeys;
  assign scLevel    = effLevel;
  assign scBothKeys = (effLevel != 3'd0) && effBoth;

  // read mux
  always_comb begin
    busRdata = '0;
    if (winHit) begin
      busRdata = winMem[winIdx];
    end else begin
      case (busAddr)
        OFF_LINE:  busRdata = {{(DATA_W-2){1'b0}}, lineSize};
        OFF_DEST:  busRdata = {{(DATA_W-1){1'b0}}, destSel};
        OFF_ADDR:  busRdata = DATA_W'(jobAddr);
        OFF_STATE: busRdata = {{(DATA_W-9){1'b0}}, errFlag, 6'b0, state};
        OFF_VER:   busRdata = DATA_W'(VERSION);
        OFF_SCW:   busRdata = {{(DATA_W-5){1'b0}}, scwReg};
        default:   busRdata = '0;
      endcase
    end
  end

  // R5: destroy leaves an all-zero buffer
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearResult |=> (resultBuf == '0));

  // R8: parameters are frozen while a job is in flight
  a_r8_param_lock: assert property (@(posedge clk) disable iff (!rstN)
    !strb.paramWrOk |=> ($stable(lineSize) && $stable(destSel) &&
                         $stable(jobAddr) && $stable(scwReg)));

  // R3: a freshly captured result is not yet visible
  a_r3_capture_hidden: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureResult |=> !showResult);

endmodule

// File: rtl/crypt_job_ctrl.sv
module crypt_job_ctrl
  import crypt_job_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int WIN_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWe,
  input  logic [11:0]            busAddr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  output logic                   engStart,
  output logic [WIN_BYTES*8-1:0] engPlain,
  output logic [1:0]             engLineSize,
  output logic [ADDR_W-1:0]      engAddr,
  input  logic                   engDone,
  input  logic [WIN_BYTES*8-1:0] engResult,
  input  logic [2:0]             fuseLevel,
  input  logic                   fuseBothKeys,
  output logic [2:0]             scLevel,
  output logic                   scBothKeys,
  output logic                   resultVisible,
  output logic [WIN_BYTES*8-1:0] resultData
);

  jobState_t  state;
  logic       errFlag;
  jobStrobe_t strb;
  logic       destSel;

  crypt_job_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .cmdBit   (busWdata[0]),
    .lineSize (engLineSize),
    .destSel  (destSel),
    .addrLow  (engAddr[5:0]),
    .engDone  (engDone),
    .state    (state),
    .errFlag  (errFlag),
    .engStart (engStart),
    .strb     (strb)
  );

  assign resultVisible = (state == JOB_SHOWN);

  crypt_job_regs #(
    .ADDR_W    (ADDR_W),
    .WIN_BYTES (WIN_BYTES)
  ) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .busWe        (busWe),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .strb         (strb),
    .state        (state),
    .errFlag      (errFlag),
    .showResult   (resultVisible),
    .engResult    (engResult),
    .fuseLevel    (fuseLevel),
    .fuseBothKeys (fuseBothKeys),
    .engPlain     (engPlain),
    .lineSize     (engLineSize),
    .destSel      (destSel),
    .jobAddr      (engAddr),
    .scLevel      (scLevel),
    .scBothKeys   (scBothKeys),
    .resultData   (resultData)
  );

  // R4: the memory path only sees data once the result is released
  a_r4_data_needs_release: assert property (@(posedge clk) disable iff (!rstN)
    (resultData != '0) |-> resultVisible);

endmodule

// File: tb/crypt_job_ctrl_tb_top.sv
module crypt_job_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 6;
  localparam int WORDS      = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWe = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         engStart;
  logic [511:0] engPlain;
  logic [1:0]   engLineSize;
  logic [25:0]  engAddr;
  logic         engDone;
  logic [511:0] engResult;
  logic [2:0]   fuseLevel = 3'd5;
  logic         fuseBothKeys = 1'b1;
  logic [2:0]   scLevel;
  logic         scBothKeys;
  logic         resultVisible;
  logic [511:0] resultData;

  int nChecks = 0;
  int nErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crypt_job_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .engStart(engStart), .engPlain(engPlain),
    .engLineSize(engLineSize), .engAddr(engAddr), .engDone(engDone),
    .engResult(engResult), .fuseLevel(fuseLevel), .fuseBothKeys(fuseBothKeys),
    .scLevel(scLevel), .scBothKeys(scBothKeys), .resultVisible(resultVisible),
    .resultData(resultData)
  );

  // placeholder engine: inverse of the plaintext, LAT cycles after start
  logic [511:0] engLatch = '0;
  int           engCnt = 0;
  int           startCount = 0;
  logic         modelDone = 1'b0;
  logic         manualDone = 1'b0;
  assign engDone   = modelDone | manualDone;
  assign engResult = manualDone ? {16{32'hDEADBEEF}} : engLatch;

  always @(negedge clk) begin
    modelDone = 1'b0;
    if (engStart) begin
      startCount++;
      engLatch = ~engPlain;
      engCnt = LAT;
    end else if (engCnt > 0) begin
      engCnt--;
      if (engCnt == 0) modelDone = 1'b1;
    end
  end

  logic [31:0]  pw [WORDS];
  logic [511:0] expPlain;

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    manualDone = 1'b1;
    @(negedge clk);
    manualDone = 1'b0;
  endtask

  task automatic waitHidden();
    logic [31:0] d;
    for (int i = 0; i < 40; i++) begin
      busRead(12'h358, d);
      if (d[1:0] == 2'd2) break;
    end
  endtask

  task automatic fillWindow(input logic [31:0] seed);
    for (int i = 0; i < WORDS; i++) begin
      pw[i] = seed ^ (32'h01010101 * (i + 1));
      busWrite(12'h300 + 12'(4*i), pw[i]);
    end
    for (int i = 0; i < WORDS; i++) expPlain[i*32 +: 32] = pw[i];
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(12'h358, d); chk("R1 state", d, 0);
    busRead(12'h340, d); chk("R1 line", d, 0);
    busRead(12'h344, d); chk("R1 dest", d, 0);
    busRead(12'h348, d); chk("R1 addr", d, 0);
    busRead(12'h35C, d); chk("R1 version", d, 32'h20201010);
    busRead(12'h388, d); chk("R1 scword", d, 32'h0F);
    chk("R1 visible", resultVisible, 0);
    chk("R1 start", engStart, 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    fillWindow(32'hA5000000);
    busRead(12'h300, d); chk("R8 win0", d, pw[0]);
    busRead(12'h33C, d); chk("R8 win15", d, pw[15]);
    busRead(12'h324, d); chk("R8 win9", d, pw[9]);
  endtask

  task automatic t_full_job();
    logic [31:0] d;
    int s0;
    busWrite(12'h340, 32'd1);
    busWrite(12'h348, 32'h0000_1220);
    s0 = startCount;
    busWrite(12'h34C, 32'd1);
    chk("R2 start high", engStart, 1);
    chk("R2 plain", engPlain, expPlain);
    chk("R2 line", engLineSize, 2'd1);
    chk("R2 addr", engAddr, 26'h1220);
    @(negedge clk);
    chk("R2 start single", engStart, 0);
    busRead(12'h358, d); chk("R2 state busy", d, 1);
    busWrite(12'h34C, 32'd1);
    busRead(12'h358, d); chk("R6 trigger in busy", d, 1);
    waitHidden();
    busRead(12'h358, d); chk("R3 state hidden", d, 2);
    chk("R2 one start", startCount - s0, 1);
    chk("R3 visible low", resultVisible, 0);
    chk("R3 data zero", resultData, 0);
    busWrite(12'h300, 32'h12345678);
    busRead(12'h300, d); chk("R8 window locked", d, pw[0]);
    busWrite(12'h348, 32'h40);
    busRead(12'h348, d); chk("R8 addr locked", d, 32'h1220);
    busWrite(12'h388, 32'h10);
    busRead(12'h388, d); chk("R8 scword locked", d, 32'h0F);
    busWrite(12'h354, 32'd1);
    busRead(12'h358, d); chk("R6 destroy in hidden", d, 2);
    busWrite(12'h350, 32'd1);
    busRead(12'h358, d); chk("R4 state shown", d, 3);
    chk("R4 visible", resultVisible, 1);
    chk("R4 data", resultData, ~expPlain);
    pulseDone();
    chk("R6 done in shown", resultData, ~expPlain);
    busWrite(12'h350, 32'd1);
    busRead(12'h358, d); chk("R6 release in shown", d, 3);
    busWrite(12'h354, 32'd1);
    busRead(12'h358, d); chk("R5 state idle", d, 0);
    chk("R5 visible low", resultVisible, 0);
    chk("R5 data zero", resultData, 0);
  endtask

  task automatic t_reject();
    logic [31:0] d;
    int s0;
    s0 = startCount;
    busWrite(12'h340, 32'd3);
    busWrite(12'h348, 32'h0);
    busWrite(12'h34C, 32'd1);
    busRead(12'h358, d); chk("R7 reserved size", d, 32'h100);
    busWrite(12'h340, 32'd2);
    busWrite(12'h348, 32'h20);
    busWrite(12'h34C, 32'd1);
    busRead(12'h358, d); chk("R7 misaligned 64", d, 32'h100);
    busWrite(12'h348, 32'h40);
    busWrite(12'h344, 32'd1);
    busWrite(12'h34C, 32'd1);
    busRead(12'h358, d); chk("R7 dest one", d, 32'h100);
    chk("R7 no start", startCount - s0, 0);
    busWrite(12'h344, 32'd0);
    busWrite(12'h340, 32'd0);
    busWrite(12'h348, 32'h10);
    fillWindow(32'h3C000000);
    busWrite(12'h34C, 32'd1);
    busRead(12'h358, d); chk("R7 accepted clears flag", d, 1);
    chk("R7 start 16B", startCount - s0, 1);
    waitHidden();
    busWrite(12'h350, 32'd1);
    chk("R4 data second job", resultData, ~expPlain);
    busWrite(12'h354, 32'd1);
    busRead(12'h358, d); chk("R5 back idle", d, 0);
  endtask

  task automatic t_idle_ignore();
    logic [31:0] d;
    pulseDone();
    busRead(12'h358, d); chk("R6 done in idle", d, 0);
    busWrite(12'h350, 32'd1);
    busRead(12'h358, d); chk("R6 release in idle", d, 0);
    busWrite(12'h354, 32'd1);
    busRead(12'h358, d); chk("R6 destroy in idle", d, 0);
    busRead(12'h34C, d); chk("R6 trig reads 0", d, 0);
    busRead(12'h350, d); chk("R6 rel reads 0", d, 0);
    busRead(12'h354, d); chk("R6 kill reads 0", d, 0);
    chk("R6 visible low", resultVisible, 0);
  endtask

  task automatic t_sidechan();
    logic [31:0] d;
    @(negedge clk);
    chk("R9 fuse level", scLevel, 3'd5);
    chk("R9 fuse both", scBothKeys, 1);
    busWrite(12'h388, 32'h12);
    chk("R9 reg level", scLevel, 3'd2);
    chk("R9 reg both off", scBothKeys, 0);
    busWrite(12'h388, 32'h18);
    chk("R9 level zero", scLevel, 3'd0);
    chk("R9 both forced off", scBothKeys, 0);
    busWrite(12'h388, 32'h00);
    fuseLevel = 3'd0;
    #1;
    chk("R9 fuse zero both off", scBothKeys, 0);
    busRead(12'h388, d); chk("R9 word readback", d, 0);
  endtask

  task automatic t_widths();
    logic [31:0] d;
    busWrite(12'h348, 32'hFFFF_FFC0);
    busRead(12'h348, d); chk("R10 addr width", d, 32'h03FF_FFC0);
    busWrite(12'h35C, 32'h0);
    busRead(12'h35C, d); chk("R10 version ro", d, 32'h20201010);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_window();
    t_full_job();
    t_reject();
    t_idle_ignore();
    t_sidechan();
    t_widths();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule